// File: doc/BRIEF.md
# Sixteen-bit Flag-Producing ALU

A combinational 16-bit arithmetic and logic unit with a flag register behind it. Each cycle it takes a source operand, a register operand, a small immediate, an incoming carry, a 4-bit operation class and two mode bits (`alt1`, `alt2`). It returns a 16-bit result, a signal that tells the surrounding datapath not to write that result back, and the four registered condition flags: overflow, sign, carry and zero.

The mode bits pick both the operand source and the variant of the operation. With `alt2` set, most classes use the zero-extended immediate as the second operand. Subtract has four variants: plain, with borrow, immediate, and compare. Compare produces flags but no writeback. The new flags for an operation are loaded into the flag register on a clock edge only when `flag_we` is high. A flag that an operation does not define keeps its registered value.

Operation class codes: 0 add, 1 subtract, 2 and/bit-clear, 3 or/xor, 4 logical shift right, 5 arithmetic shift right, 6 rotate left, 7 rotate right, 8 byte swap, 9 sign-extend byte, 10 low byte, 11 high byte, 12 invert, 13 merge, 14 and 15 reserved.

Top module: `flag_alu16`

## Requirements
- R1: The second operand is `reg_b` when `alt2`=0 and the zero-extended `imm` when `alt2`=1. The exception is class 1 with `alt1`=1 and `alt2`=1, which uses `reg_b`.
- R2: Class 0 computes `src_a` + operand, plus `carry_in` only when `alt1`=1. Carry is set when the unsigned sum reaches 0x10000. Overflow is bit 15 of (~(a^b) & (b^r)). Sign is result bit 15, and zero is set when the result is 0.
- R3: Class 1 computes `src_a` − operand. When `alt1`=1 and `alt2`=0 it also subtracts the inverse of `carry_in`. Carry is set when no borrow occurs. Overflow is bit 15 of ((a^b) & (a^r)). Sign and zero are set as in R2.
- R4: Class 1 with `alt1`=1 and `alt2`=1 is compare. It raises `wb_suppress` and produces the same flags as a plain subtract. All other classes 0–13 leave `wb_suppress` low.
- R5: Class 4 shifts right with a zero in bit 15. Class 5 shifts right and keeps bit 15, and with `alt1`=1 an input of 0xFFFF gives 0. In both classes the carry takes old bit 0, and sign and zero follow the result.
- R6: Class 6 shifts left with `carry_in` entering bit 0 and old bit 15 going to carry. Class 7 shifts right with `carry_in` entering bit 15 and old bit 0 going to carry. Sign and zero follow the result.
- R7: Class 13 returns {`src_a`[15:8], `reg_b`[15:8]}. Each flag is set when any result bit under its own mask is 1: overflow 0xC0C0, sign 0x8080, carry 0xE0E0, zero 0xF0F0.
- R8: Class 8 exchanges the two bytes of `src_a`. Class 9 copies bit 7 into bits 15:8. Classes 10 and 11 return the low or high byte of `src_a` zero-extended, with the sign taken from result bit 7. Classes 8 and 9 take the sign from bit 15. Zero follows the result in all four.
- R9: Class 2 returns `src_a` & operand, or `src_a` & ~operand when `alt1`=1. Class 3 returns or, or xor when `alt1`=1. Class 12 returns ~`src_a`. Sign and zero follow the result.
- R10: Flags that an operation does not define keep their registered values. Overflow is untouched by classes 2–12, and carry is untouched by classes 2, 3 and 8–12.
- R11: While `flag_we` is low, the flag outputs do not change.
- R12: With `flag_we` high, the flags computed in that cycle appear on the flag outputs after the next rising edge. A synchronous `rst` clears all four flags.
- R13: Classes 14 and 15 return `src_a` unchanged, raise `wb_suppress` and define no flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the flag register |
| op_class | input | 4 | Operation class code |
| alt1 | input | 1 | Variant mode bit |
| alt2 | input | 1 | Immediate / variant mode bit |
| src_a | input | 16 | Source operand |
| reg_b | input | 16 | Register operand, also the low-byte donor for merge |
| imm | input | 4 | Immediate operand |
| carry_in | input | 1 | Incoming carry for add, subtract-with-borrow and rotates |
| flag_we | input | 1 | Load the computed flags at the next edge |
| result | output | 16 | Combinational result |
| wb_suppress | output | 1 | Result must not be written back |
| flag_ov | output | 1 | Registered overflow flag |
| flag_s | output | 1 | Registered sign flag |
| flag_cy | output | 1 | Registered carry flag |
| flag_z | output | 1 | Registered zero flag |

## Verification
Two things can happen in the same cycle: the flag register loads the result of one operation, and the combinational path computes the next operation from a carry that was just registered. The bench provokes this by feeding the registered carry back into `carry_in` in about half of its random cycles, with `flag_we` toggled at random. Each step judges both the immediate result and the flags that arrive one edge later against a bench-side model. Directed cases cover a compare issued while the flags are being loaded, and a partial-flag operation that must keep an overflow set by the operation before it.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

    localparam int DATA_W = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        OPC_ADD   = 4'd0,
        OPC_SUB   = 4'd1,
        OPC_AND   = 4'd2,
        OPC_OR    = 4'd3,
        OPC_LSR   = 4'd4,
        OPC_ASR   = 4'd5,
        OPC_ROL   = 4'd6,
        OPC_ROR   = 4'd7,
        OPC_SWAP  = 4'd8,
        OPC_SEXT  = 4'd9,
        OPC_LOWB  = 4'd10,
        OPC_HIGHB = 4'd11,
        OPC_INV   = 4'd12,
        OPC_MERGE = 4'd13,
        OPC_RSV0  = 4'd14,
        OPC_RSV1  = 4'd15
    } opc_e;

    typedef struct packed {
        logic ov;
        logic s;
        logic cy;
        logic z;
    } flags_t;

    typedef struct packed {
        logic [DATA_W-1:0] val;
        flags_t            f;
        flags_t            upd;
    } alu_out_t;

    localparam logic [DATA_W-1:0] MRG_OV_MASK = 16'hC0C0;
    localparam logic [DATA_W-1:0] MRG_S_MASK  = 16'h8080;
    localparam logic [DATA_W-1:0] MRG_CY_MASK = 16'hE0E0;
    localparam logic [DATA_W-1:0] MRG_Z_MASK  = 16'hF0F0;

    function automatic logic is_zero(input logic [DATA_W-1:0] v);
        return (v == '0);
    endfunction

    function automatic flags_t merge_flags(input flags_t upd, input flags_t fresh,
                                           input flags_t held);
        flags_t r;
        r.ov = upd.ov ? fresh.ov : held.ov;
        r.s  = upd.s  ? fresh.s  : held.s;
        r.cy = upd.cy ? fresh.cy : held.cy;
        r.z  = upd.z  ? fresh.z  : held.z;
        return r;
    endfunction

endpackage

// File: rtl/alu16_operand.sv
module alu16_operand
    import alu16_pkg::*;
#(
    parameter int IMM_W = 4
) (
    input  opc_e              opc,
    input  logic              alt1,
    input  logic              alt2,
    input  logic [DATA_W-1:0] reg_b,
    input  logic [IMM_W-1:0]  imm,
    output logic [DATA_W-1:0] operand_b,
    output logic              use_imm
);
    localparam int PAD_W = DATA_W - IMM_W;

    always_comb begin
        use_imm   = alt2 && !((opc == OPC_SUB) && alt1);
        operand_b = use_imm ? {{PAD_W{1'b0}}, imm} : reg_b;
    end
endmodule

// File: rtl/alu16_arith.sv
module alu16_arith
    import alu16_pkg::*;
(
    input  logic              do_sub,
    input  logic              alt1,
    input  logic              alt2,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    output alu_out_t          out
);
    localparam int EXT_W = DATA_W + 1;

    logic [EXT_W-1:0]  sum_x;
    logic [EXT_W-1:0]  dif_x;
    logic              add_ci;
    logic              sub_bi;
    logic [DATA_W-1:0] r;

    always_comb begin
        add_ci = alt1 & cin;
        sub_bi = alt1 & ~alt2 & ~cin;
        sum_x  = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, add_ci};
        dif_x  = {1'b0, a} - {1'b0, b} - {{DATA_W{1'b0}}, sub_bi};
        r      = do_sub ? dif_x[DATA_W-1:0] : sum_x[DATA_W-1:0];

        out.val  = r;
        out.f.s  = r[DATA_W-1];
        out.f.z  = is_zero(r);
        if (do_sub) begin
            out.f.cy = ~dif_x[DATA_W];
            out.f.ov = (a[DATA_W-1] ^ b[DATA_W-1]) & (a[DATA_W-1] ^ r[DATA_W-1]);
        end else begin
            out.f.cy = sum_x[DATA_W];
            out.f.ov = ~(a[DATA_W-1] ^ b[DATA_W-1]) & (b[DATA_W-1] ^ r[DATA_W-1]);
        end
        out.upd = '{ov: 1'b1, s: 1'b1, cy: 1'b1, z: 1'b1};
    end
endmodule

// File: rtl/alu16_bitops.sv
module alu16_bitops
    import alu16_pkg::*;
(
    input  opc_e              opc,
    input  logic              alt1,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [BYTE_W-1:0] rb_hi,
    input  logic              cin,
    output alu_out_t          out
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] v;
    logic              halve_fix;

    always_comb begin
        v         = a;
        halve_fix = alt1 && (a == {DATA_W{1'b1}});
        out.f     = '0;
        out.upd   = '0;

        unique case (opc)
            OPC_AND:   v = a & (alt1 ? ~b : b);
            OPC_OR:    v = alt1 ? (a ^ b) : (a | b);
            OPC_LSR:   v = {1'b0, a[MSB:1]};
            OPC_ASR:   v = halve_fix ? '0 : {a[MSB], a[MSB:1]};
            OPC_ROL:   v = {a[MSB-1:0], cin};
            OPC_ROR:   v = {cin, a[MSB:1]};
            OPC_SWAP:  v = {a[BYTE_W-1:0], a[MSB:BYTE_W]};
            OPC_SEXT:  v = {{(DATA_W-BYTE_W){a[BYTE_W-1]}}, a[BYTE_W-1:0]};
            OPC_LOWB:  v = {{(DATA_W-BYTE_W){1'b0}}, a[BYTE_W-1:0]};
            OPC_HIGHB: v = {{(DATA_W-BYTE_W){1'b0}}, a[MSB:BYTE_W]};
            OPC_INV:   v = ~a;
            OPC_MERGE: v = {a[MSB:BYTE_W], rb_hi};
            default:   v = a;
        endcase

        // default sign/zero source for the byte-wide and word-wide ops
        out.f.s = v[MSB];
        out.f.z = is_zero(v);

        unique case (opc)
            OPC_AND, OPC_OR, OPC_SWAP, OPC_SEXT, OPC_INV: begin
                out.upd.s = 1'b1;
                out.upd.z = 1'b1;
            end
            OPC_LOWB, OPC_HIGHB: begin
                out.f.s   = v[BYTE_W-1];
                out.upd.s = 1'b1;
                out.upd.z = 1'b1;
            end
            OPC_LSR, OPC_ASR, OPC_ROR: begin
                out.f.cy   = a[0];
                out.upd.s  = 1'b1;
                out.upd.z  = 1'b1;
                out.upd.cy = 1'b1;
            end
            OPC_ROL: begin
                out.f.cy   = a[MSB];
                out.upd.s  = 1'b1;
                out.upd.z  = 1'b1;
                out.upd.cy = 1'b1;
            end
            OPC_MERGE: begin
                out.f.ov = |(v & MRG_OV_MASK);
                out.f.s  = |(v & MRG_S_MASK);
                out.f.cy = |(v & MRG_CY_MASK);
                out.f.z  = |(v & MRG_Z_MASK);
                out.upd  = '{ov: 1'b1, s: 1'b1, cy: 1'b1, z: 1'b1};
            end
            default: out.upd = '0;
        endcase

        out.val = v;
    end
endmodule

// File: rtl/flag_alu16.sv
module flag_alu16
    import alu16_pkg::*;
#(
    parameter int IMM_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        op_class,
    input  logic              alt1,
    input  logic              alt2,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] reg_b,
    input  logic [IMM_W-1:0]  imm,
    input  logic              carry_in,
    input  logic              flag_we,
    output logic [DATA_W-1:0] result,
    output logic              wb_suppress,
    output logic              flag_ov,
    output logic              flag_s,
    output logic              flag_cy,
    output logic              flag_z
);
    opc_e              opc;
    logic [DATA_W-1:0] opnd_b;
    logic              opnd_imm;
    logic              arith_sel;
    alu_out_t          arith_o;
    alu_out_t          bit_o;
    alu_out_t          pick;
    flags_t            flag_q;
    flags_t            flag_nx;

    assign opc = opc_e'(op_class);

    alu16_operand #(.IMM_W(IMM_W)) u_operand (
        .opc       (opc),
        .alt1      (alt1),
        .alt2      (alt2),
        .reg_b     (reg_b),
        .imm       (imm),
        .operand_b (opnd_b),
        .use_imm   (opnd_imm)
    );

    alu16_arith u_arith (
        .do_sub (opc == OPC_SUB),
        .alt1   (alt1),
        .alt2   (alt2),
        .a      (src_a),
        .b      (opnd_b),
        .cin    (carry_in),
        .out    (arith_o)
    );

    alu16_bitops u_bitops (
        .opc   (opc),
        .alt1  (alt1),
        .a     (src_a),
        .b     (opnd_b),
        .rb_hi (reg_b[DATA_W-1:BYTE_W]),
        .cin   (carry_in),
        .out   (bit_o)
    );

    always_comb begin
        arith_sel   = (opc == OPC_ADD) || (opc == OPC_SUB);
        pick        = arith_sel ? arith_o : bit_o;
        result      = pick.val;
        flag_nx     = merge_flags(pick.upd, pick.f, flag_q);
        wb_suppress = ((opc == OPC_SUB) && alt1 && alt2) ||
                      (opc == OPC_RSV0) || (opc == OPC_RSV1);
    end

    always_ff @(posedge clk) begin
        if (rst)          flag_q <= '0;
        else if (flag_we) flag_q <= flag_nx;
    end

    assign flag_ov = flag_q.ov;
    assign flag_s  = flag_q.s;
    assign flag_cy = flag_q.cy;
    assign flag_z  = flag_q.z;

    // immediate only ever reaches the datapath with alt2 high
    assert_imm_path_R1: assert property (@(posedge clk) disable iff (rst)
        opnd_imm |-> alt2);

    assert_cmp_nowb_R4: assert property (@(posedge clk) disable iff (rst)
        (opc == OPC_SUB && alt1 && alt2) |-> (wb_suppress && flag_nx.ov ==
            ((src_a[15] ^ reg_b[15]) & (src_a[15] ^ result[15]))));

    assert_lsr_shape_R5: assert property (@(posedge clk) disable iff (rst)
        (opc == OPC_LSR) |-> (!result[15] && flag_nx.cy == src_a[0]));

    assert_rotl_R6: assert property (@(posedge clk) disable iff (rst)
        (opc == OPC_ROL) |-> (result[0] == carry_in && flag_nx.cy == src_a[15]));

    assert_merge_sign_R7: assert property (@(posedge clk) disable iff (rst)
        (opc == OPC_MERGE) |-> (flag_nx.s == (result[15] | result[7])));

    assert_keep_ov_R10: assert property (@(posedge clk) disable iff (rst)
        (op_class >= 4'd2 && op_class <= 4'd12) |-> (flag_nx.ov == flag_q.ov));

    assert_hold_flags_R11: assert property (@(posedge clk) disable iff (rst)
        !flag_we |=> $stable(flag_q));

    assert_flag_load_R12: assert property (@(posedge clk) disable iff (rst)
        flag_we |=> (flag_q == $past(flag_nx)));

    assert_rsv_pass_R13: assert property (@(posedge clk) disable iff (rst)
        (opc == OPC_RSV0 || opc == OPC_RSV1) |-> (wb_suppress && result == src_a
            && flag_nx == flag_q));
endmodule

// File: tb/tb_flag_alu16.sv
module tb_flag_alu16;
    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  op_class;
    logic        alt1, alt2;
    logic [15:0] src_a, reg_b;
    logic [3:0]  imm;
    logic        carry_in, flag_we;
    logic [15:0] result;
    logic        wb_suppress, flag_ov, flag_s, flag_cy, flag_z;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit [3:0] model_f;      // {ov, s, cy, z}
    string    flag_tag;

    always #4 clk = ~clk;

    flag_alu16 dut (
        .clk(clk), .rst(rst), .op_class(op_class), .alt1(alt1), .alt2(alt2),
        .src_a(src_a), .reg_b(reg_b), .imm(imm), .carry_in(carry_in),
        .flag_we(flag_we), .result(result), .wb_suppress(wb_suppress),
        .flag_ov(flag_ov), .flag_s(flag_s), .flag_cy(flag_cy), .flag_z(flag_z)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic string tag_of(input int op, input bit a1, input bit a2);
        case (op)
            0: return "R2";
            1: return (a1 && a2) ? "R4" : "R3";
            2, 3, 12: return "R9";
            4, 5: return "R5";
            6, 7: return "R6";
            8, 9, 10, 11: return "R8";
            13: return "R7";
            default: return "R13";
        endcase
    endfunction

    task automatic ref_model(input int op, input bit a1, input bit a2,
                             input bit [15:0] a, input bit [15:0] rb,
                             input bit [3:0] im, input bit ci, input bit [3:0] fin,
                             output bit [15:0] r, output bit sup, output bit [3:0] fo);
        bit ov, s, cy, z;
        bit [15:0] bb;
        int t;
        {ov, s, cy, z} = fin;
        sup = 0;
        bb  = (a2 && !(op == 1 && a1)) ? {12'd0, im} : rb;
        r   = a;
        case (op)
            0: begin
                t  = int'(a) + int'(bb) + ((a1 && ci) ? 1 : 0);
                r  = t[15:0]; cy = (t >= 65536);
                ov = ~(a[15] ^ bb[15]) & (bb[15] ^ r[15]);
                s = r[15]; z = (r == 0);
            end
            1: begin
                t  = int'(a) - int'(bb) - ((a1 && !a2 && !ci) ? 1 : 0);
                r  = t[15:0]; cy = (t >= 0);
                ov = (a[15] ^ bb[15]) & (a[15] ^ r[15]);
                s = r[15]; z = (r == 0); sup = a1 && a2;
            end
            2:  begin r = a1 ? (a & ~bb) : (a & bb); s = r[15]; z = (r == 0); end
            3:  begin r = a1 ? (a ^ bb) : (a | bb);  s = r[15]; z = (r == 0); end
            4:  begin r = a >> 1; cy = a[0]; s = r[15]; z = (r == 0); end
            5:  begin
                r = (a1 && a == 16'hFFFF) ? 16'h0 : {a[15], a[15:1]};
                cy = a[0]; s = r[15]; z = (r == 0);
            end
            6:  begin r = {a[14:0], ci}; cy = a[15]; s = r[15]; z = (r == 0); end
            7:  begin r = {ci, a[15:1]}; cy = a[0];  s = r[15]; z = (r == 0); end
            8:  begin r = {a[7:0], a[15:8]}; s = r[15]; z = (r == 0); end
            9:  begin r = {{8{a[7]}}, a[7:0]}; s = r[15]; z = (r == 0); end
            10: begin r = {8'd0, a[7:0]};  s = r[7]; z = (r == 0); end
            11: begin r = {8'd0, a[15:8]}; s = r[7]; z = (r == 0); end
            12: begin r = ~a; s = r[15]; z = (r == 0); end
            13: begin
                r  = {a[15:8], rb[15:8]};
                ov = |(r & 16'hC0C0); s = |(r & 16'h8080);
                cy = |(r & 16'hE0E0); z = |(r & 16'hF0F0);
            end
            default: begin r = a; sup = 1; end
        endcase
        fo = {ov, s, cy, z};
    endtask

    task automatic apply(input int op, input bit a1, input bit a2, input bit [15:0] a,
                         input bit [15:0] rb, input bit [3:0] im, input bit ci,
                         input bit we, input string xtag);
        bit [15:0] er; bit es; bit [3:0] ef;
        @(negedge clk);
        chk({flag_ov, flag_s, flag_cy, flag_z} == model_f, flag_tag, "flags",
            {flag_ov, flag_s, flag_cy, flag_z}, model_f);
        op_class = op[3:0]; alt1 = a1; alt2 = a2; src_a = a; reg_b = rb;
        imm = im; carry_in = ci; flag_we = we;
        #1;
        ref_model(op, a1, a2, a, rb, im, ci, model_f, er, es, ef);
        chk(result == er, {tag_of(op, a1, a2), " ", xtag}, "result", result, er);
        chk(wb_suppress == es, {tag_of(op, a1, a2), " ", xtag}, "wb_suppress",
            wb_suppress, es);
        if (we) begin
            model_f  = ef;
            flag_tag = {"R12 R10 ", tag_of(op, a1, a2)};
        end else begin
            flag_tag = "R11";
        end
    endtask

    task automatic settle(input string tag);
        @(negedge clk);
        chk({flag_ov, flag_s, flag_cy, flag_z} == model_f, tag, "flags",
            {flag_ov, flag_s, flag_cy, flag_z}, model_f);
        flag_we  = 0;
        flag_tag = "R11";
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 32'h5EED_A1B7;
        void'($urandom(seed));
        rst = 1; op_class = 0; alt1 = 0; alt2 = 0; src_a = 0; reg_b = 0;
        imm = 0; carry_in = 0; flag_we = 1;
        model_f = 4'b0; flag_tag = "R12";
        repeat (3) @(negedge clk);
        chk({flag_ov, flag_s, flag_cy, flag_z} == 4'b0, "R12", "reset flags",
            {flag_ov, flag_s, flag_cy, flag_z}, 0);
        rst = 0; flag_we = 0;

        // directed corner cases
        apply(0, 0, 0, 16'hFFFF, 16'h0001, 4'h0, 0, 1, "R2 wrap to zero");
        settle("R2");
        apply(0, 1, 0, 16'h7FFF, 16'h0000, 4'h0, 1, 1, "R2 carry-in overflow");
        settle("R2");
        apply(0, 0, 1, 16'h0010, 16'h0100, 4'h5, 0, 1, "R1 immediate add");
        apply(1, 0, 0, 16'h8000, 16'h0001, 4'h0, 0, 1, "R3 overflow");
        settle("R3");
        apply(1, 1, 0, 16'h0005, 16'h0003, 4'h0, 0, 1, "R3 with borrow");
        apply(1, 0, 1, 16'h0014, 16'hFFFF, 4'h4, 0, 1, "R1 sub immediate");
        apply(1, 1, 1, 16'h1234, 16'h1234, 4'h9, 0, 1, "R4 R1 compare equal");
        settle("R4");
        apply(1, 1, 1, 16'h0001, 16'h0002, 4'h0, 0, 1, "R4 compare less");
        apply(5, 1, 0, 16'hFFFF, 16'h0, 4'h0, 0, 1, "R5 halve minus one");
        settle("R5");
        apply(5, 0, 0, 16'hFFFF, 16'h0, 4'h0, 0, 1, "R5 arith shift");
        apply(5, 1, 0, 16'hFFFE, 16'h0, 4'h0, 0, 1, "R5 halve minus two");
        apply(4, 0, 0, 16'h8001, 16'h0, 4'h0, 0, 1, "R5 logical shift");
        apply(6, 0, 0, 16'h8000, 16'h0, 4'h0, 1, 1, "R6 rotate left");
        apply(7, 0, 0, 16'h0001, 16'h0, 4'h0, 1, 1, "R6 rotate right");
        apply(13, 0, 0, 16'hC3AA, 16'h12FF, 4'h0, 0, 1, "R7 merge");
        settle("R7");
        apply(13, 0, 0, 16'h0F55, 16'h0F00, 4'h0, 0, 1, "R7 merge clear masks");
        apply(10, 0, 0, 16'h7F80, 16'h0, 4'h0, 0, 1, "R8 low byte sign");
        apply(11, 0, 0, 16'h80FF, 16'h0, 4'h0, 0, 1, "R8 high byte sign");
        apply(9, 0, 0, 16'h0080, 16'h0, 4'h0, 0, 1, "R8 sign extend");
        apply(8, 0, 0, 16'h12AB, 16'h0, 4'h0, 0, 1, "R8 swap");
        apply(2, 1, 1, 16'hFFFF, 16'h0, 4'hF, 0, 1, "R9 R1 bit clear immediate");
        apply(3, 1, 0, 16'hAAAA, 16'hFFFF, 4'h0, 0, 1, "R9 xor");
        // set overflow, then a partial-flag op must keep it
        apply(1, 0, 0, 16'h8000, 16'h0001, 4'h0, 0, 1, "R3 set ov");
        apply(12, 0, 0, 16'h0000, 16'h0, 4'h0, 0, 1, "R10 invert keeps ov");
        settle("R10");
        chk(flag_ov == 1'b1, "R10", "ov kept", flag_ov, 1);
        apply(14, 1, 1, 16'hBEEF, 16'h1234, 4'h3, 1, 1, "R13 reserved");
        apply(15, 0, 0, 16'h0000, 16'hFFFF, 4'h0, 0, 1, "R13 reserved");
        settle("R13");
        apply(0, 0, 0, 16'hFFFF, 16'h0001, 4'h0, 0, 0, "R11 no load");
        settle("R11");

        // constrained random, carry often chained from the flag register
        for (int i = 0; i < 4000; i++) begin
            bit [3:0] rop = 4'($urandom % 16);
            bit       ci  = ($urandom % 2) ? model_f[1] : 1'($urandom % 2);
            bit [15:0] ra;
            case ($urandom % 4)
                0: ra = 16'hFFFF;
                1: ra = 16'($urandom % 4);
                default: ra = 16'($urandom);
            endcase
            apply(int'(rop), 1'($urandom % 2), 1'($urandom % 2), ra, 16'($urandom),
                  4'($urandom), ci, 1'($urandom % 3 != 0), "random");
        end
        settle("R12");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule